// File: doc/BRIEF.md
# Ready-Thread Barrel Issue Scheduler

This block decides, once per clock, which hardware thread may send its next instruction into a deep pipeline. Each thread has at most one instruction in flight. Issue alternates between threads, so an instruction never sits directly behind a dependent instruction from the same thread, and the pipeline needs no forwarding paths.

There are two modes. In static mode the scheduler walks through every thread slot in a fixed cyclic order, one slot per cycle, whether or not the thread is ready. With the default of eight threads, this hides an eight-cycle pipelined memory latency. In dynamic mode it grants only threads marked ready. A thread becomes ready when its last instruction reports completion. It can also stay ready straight through an issue if that instruction carries a no-dependence hint. A rotating priority pointer shares the grants fairly among the ready threads. Threads whose enable bit is low are never granted in either mode.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset every thread is ready, the dynamic priority pointer is at thread 0 and the static slot counter is at 0. The first grant, in either mode, goes to thread 0 when it is enabled.
- R2: In static mode (`mode_dyn` = 0) the offered thread ID advances by one every cycle and wraps from NUM_THREADS-1 to 0, regardless of readiness.
- R3: In static mode a slot whose thread has `thread_en` low is still used up, with `issue_valid` = 0 for that cycle.
- R4: In dynamic mode (`mode_dyn` = 1) only a thread whose ready bit is set and whose enable bit is set is granted.
- R5: In dynamic mode the search starts one thread past the last dynamically granted thread and wraps round. The first eligible thread found in that order is granted.
- R6: A grant whose `wake_hint` bit (bit index = thread ID) is 0 clears that thread's ready bit from the next cycle. A `done_vec` bit (bit index = thread ID) sets the thread ready from the next cycle.
- R7: A grant whose `wake_hint` bit for the granted thread is 1 leaves the thread ready, so it can be granted again without a completion report.
- R8: If a completion report and a grant for the same thread fall in the same cycle, the grant decides the next ready value.
- R9: In dynamic mode, when no thread is both ready and enabled, `issue_valid` is 0.
- R10: A thread with `thread_en` low is never granted, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dyn | input | 1 | 1 = dynamic ready-based selection, 0 = static rotation |
| thread_en | input | NUM_THREADS | Per-thread enable, bit index = thread ID |
| done_vec | input | NUM_THREADS | Per-thread completion report for the instruction in flight |
| wake_hint | input | NUM_THREADS | Per-thread no-dependence hint; only the granted thread's bit is used |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | log2(NUM_THREADS) | ID of the granted or offered thread |

## Verification
The grant outputs are combinational from the registered ready bits, the pointer and the slot counter, together with the current enable and mode inputs. An enable or mode change therefore shows in the same cycle. A completion report, a hint or a grant changes readiness only from the following cycle, and the pointer and slot counter also move one edge after a grant. The bench applies each stimulus on the falling clock edge and samples the outputs 1 ns later, before the next rising edge. Each expected value is thus compared in the cycle that the stimulus and every earlier edge have produced. The expected grant sequence in the bench's vector table was worked out by hand from R4 to R9.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

    localparam int MAX_THREADS = 128;
    localparam int MAX_TID_W   = 7;

    typedef enum logic {
        MODE_STATIC  = 1'b0,
        MODE_DYNAMIC = 1'b1
    } sched_mode_e;

    typedef struct packed {
        logic                 valid;
        logic [MAX_TID_W-1:0] tid;
    } issue_t;

endpackage

// File: rtl/sched_ready_tracker.sv
module sched_ready_tracker #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] done_vec,
    input  logic                   grant_fire,
    input  logic [TID_W-1:0]       grant_tid,
    input  logic                   grant_keep,
    output logic [NUM_THREADS-1:0] ready_q
);

    // One ready flag per thread; a grant outranks a completion report.
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_flag
        logic hit;
        assign hit = grant_fire && (grant_tid == TID_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                ready_q[g] <= 1'b1;
            end else if (hit) begin
                ready_q[g] <= grant_keep;
            end else if (done_vec[g]) begin
                ready_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sched_rr_picker.sv
module sched_rr_picker #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input  logic [NUM_THREADS-1:0] cand,
    input  logic [TID_W-1:0]       start,
    output logic                   found,
    output logic [TID_W-1:0]       pick
);

    // Scan from the start index, wrapping, first hit wins.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            idx = int'(start) + i;
            if (idx >= NUM_THREADS) begin
                idx = idx - NUM_THREADS;
            end
            if (!found && cand[idx]) begin
                found = 1'b1;
                pick  = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/sched_slot_counter.sv
module sched_slot_counter #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [TID_W-1:0] slot_q
);

    localparam logic [TID_W-1:0] LAST = TID_W'(NUM_THREADS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
    import thread_sched_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_dyn,
    input  logic [NUM_THREADS-1:0] thread_en,
    input  logic [NUM_THREADS-1:0] done_vec,
    input  logic [NUM_THREADS-1:0] wake_hint,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    sched_mode_e            mode;
    logic [NUM_THREADS-1:0] ready_q;
    logic [NUM_THREADS-1:0] cand;
    logic                   dyn_found;
    logic [TID_W-1:0]       dyn_pick;
    logic [TID_W-1:0]       ptr_q;
    logic [TID_W-1:0]       slot_q;
    issue_t                 sel;

    assign mode = sched_mode_e'(mode_dyn);
    assign cand = ready_q & thread_en;

    sched_rr_picker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick (
        .cand  (cand),
        .start (ptr_q),
        .found (dyn_found),
        .pick  (dyn_pick)
    );

    sched_slot_counter #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .advance (mode == MODE_STATIC),
        .slot_q  (slot_q)
    );

    always_comb begin
        sel = '0;
        case (mode)
            MODE_DYNAMIC: begin
                sel.valid = dyn_found;
                sel.tid   = MAX_TID_W'(dyn_pick);
            end
            default: begin
                sel.valid = thread_en[slot_q];
                sel.tid   = MAX_TID_W'(slot_q);
            end
        endcase
    end

    assign issue_valid = sel.valid;
    assign issue_tid   = sel.tid[TID_W-1:0];

    // Rotating priority: next search begins just past the last dynamic grant.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (mode == MODE_DYNAMIC && dyn_found) begin
            ptr_q <= (dyn_pick == LAST_TID) ? '0 : dyn_pick + 1'b1;
        end
    end

    sched_ready_tracker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ready (
        .clk        (clk),
        .rst        (rst),
        .done_vec   (done_vec),
        .grant_fire (issue_valid),
        .grant_tid  (issue_tid),
        .grant_keep (wake_hint[issue_tid]),
        .ready_q    (ready_q)
    );

endmodule

// File: rtl/thread_issue_sched_chk.sv
module thread_issue_sched_chk #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mode_dyn,
    input logic [NUM_THREADS-1:0] thread_en,
    input logic [NUM_THREADS-1:0] wake_hint,
    input logic                   issue_valid,
    input logic [TID_W-1:0]       issue_tid,
    input logic [NUM_THREADS-1:0] ready_q
);

    p_enabled_only_r10: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> thread_en[issue_tid]);

    p_ready_only_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_dyn && issue_valid) |-> ready_q[issue_tid]);

    p_idle_when_none_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_dyn && ((ready_q & thread_en) == '0)) |-> !issue_valid);

    p_grant_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !wake_hint[issue_tid]) |=> !ready_q[$past(issue_tid)]);

    p_hint_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && wake_hint[issue_tid]) |=> ready_q[$past(issue_tid)]);

    p_static_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_dyn && !$past(mode_dyn) && !$past(rst)) |->
        (issue_tid == (($past(issue_tid) == TID_W'(NUM_THREADS - 1)) ? '0 : $past(issue_tid) + 1'b1)));

endmodule

bind thread_issue_sched thread_issue_sched_chk #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_dyn    (mode_dyn),
    .thread_en   (thread_en),
    .wake_hint   (wake_hint),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .ready_q     (ready_q)
);

// File: tb/thread_issue_sched_tb.sv
`timescale 1ns/1ps
module thread_issue_sched_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_dyn = 1'b1;
    logic [N-1:0] thread_en = '0;
    logic [N-1:0] done_vec = '0;
    logic [N-1:0] wake_hint = '0;
    logic         issue_valid;
    logic [2:0]   issue_tid;

    int runs = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    thread_issue_sched #(.NUM_THREADS(N)) u_dut (
        .clk(clk), .rst(rst), .mode_dyn(mode_dyn), .thread_en(thread_en),
        .done_vec(done_vec), .wake_hint(wake_hint),
        .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    typedef struct packed {
        logic       dyn;
        logic [7:0] en;
        logic [7:0] done;
        logic [7:0] hint;
        logic       v;
        logic [2:0] tid;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd0, 4'd5},  // R5 from pointer 0
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd1, 4'd5},  // R5
        '{1'b1, 8'hFF, 8'h00, 8'h04, 1'b1, 3'd2, 4'd7},  // R7 hint on thread 2
        '{1'b1, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd4, 4'd10}, // R10 thread 3 disabled
        '{1'b1, 8'hFF, 8'h01, 8'h00, 1'b1, 3'd5, 4'd4},  // R4 thread 0 completes
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd6, 4'd5},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd7, 4'd5},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd0, 4'd6},  // R6 woken by completion
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd2, 4'd7},  // R7 still ready
        '{1'b1, 8'hF7, 8'h00, 8'h00, 1'b0, 3'd0, 4'd9},  // R9 only 3 ready, disabled
        '{1'b1, 8'hFF, 8'h08, 8'h00, 1'b1, 3'd3, 4'd8},  // R8 done and grant together
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0, 4'd8},  // R8 grant won
        '{1'b1, 8'hFF, 8'h30, 8'h00, 1'b0, 3'd0, 4'd6},  // R6 wake is one cycle late
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd4, 4'd6},
        '{1'b1, 8'hFF, 8'h01, 8'h00, 1'b1, 3'd5, 4'd5},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 3'd0, 4'd5},  // R5 wrap
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd0, 4'd2},  // R2 static
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd1, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd2, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b0, 3'd3, 4'd3},  // R3 slot used, not valid
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd4, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd5, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd6, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd7, 4'd2},
        '{1'b0, 8'hF7, 8'h00, 8'h00, 1'b1, 3'd0, 4'd2}   // R2 wrap
    };

    task automatic check(input string req, input logic ev, input logic [2:0] et);
        runs++;
        if (issue_valid !== ev || (ev && issue_tid !== et)) begin
            fails++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     req, issue_valid, issue_tid, ev, et);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        done_vec = '0;
        wake_hint = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            mode_dyn  = TBL[i].dyn;
            thread_en = TBL[i].en;
            done_vec  = TBL[i].done;
            wake_hint = TBL[i].hint;
            #1;
            check($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].v, TBL[i].tid);
            @(negedge clk);
        end

        // R1: reset state, dynamic mode
        do_reset();
        mode_dyn = 1'b1; thread_en = 8'hFF;
        #1; check("R1 dynamic after reset", 1'b1, 3'd0);

        // R1: reset state, static mode
        do_reset();
        mode_dyn = 1'b0; thread_en = 8'hFF;
        #1; check("R1 static after reset", 1'b1, 3'd0);

        // R6: a single thread goes idle after its grant and wakes on completion
        do_reset();
        mode_dyn = 1'b1; thread_en = 8'h01;
        #1; check("R6 first grant", 1'b1, 3'd0);
        @(negedge clk);
        done_vec = 8'h01;
        #1; check("R6 waiting", 1'b0, 3'd0);
        @(negedge clk);
        done_vec = 8'h00;
        #1; check("R6 woken", 1'b1, 3'd0);

        // R10: disabled thread is not granted even when ready
        @(negedge clk);
        thread_en = 8'h00; wake_hint = 8'h00;
        #1; check("R10 none enabled", 1'b0, 3'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            runs++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule